// File: doc/BRIEF.md
# Table Access Address Unit

This unit gives a processor data-width access to a program memory whose words are 24 bits wide. Software sees each word as two 16-bit lanes placed side by side. The low lane holds word bits 15:0. The high lane holds bits 23:16 below eight bits that do not exist and always read as zero. Each operation carries a lane choice, a read or write direction, a byte-or-word flag and a 16-bit data pointer. A software-loaded page register is placed above that pointer. The whole pointer is kept, and its bit 0 becomes the byte select, so the upper 23 bits of the result address one program word.

Reads drive the memory's read port in the same cycle as the request and return the chosen lane or byte one clock later, with a valid strobe. Reads that land outside the implemented user or configuration space do not enable the port and return zero. Writes never touch the array. They fill a 24-bit holding latch, and they record the word address the latch is meant for. Erase and programming sequencing belong to a neighbouring block.

Top module: `tbl_access_unit`

## Requirements
- R1: The page register resets to 0. A write loads the low 8 bits of `page_wr_data`, and this is visible on `page_rd_data` one clock later. Bits 15:8 of `page_rd_data` are always zero, and the register holds its value when no write is made.
- R2: Operation encoding on `op_code`: 00 reads the low lane, 01 reads the high lane, 10 writes the low lane, 11 writes the high lane. The word address is {page, op_ptr[15:1]}. Page bit 7 therefore lands in address bit 22 and selects configuration space. In the cycle of a read to implemented space, `pm_rd_en` is 1 and `pm_rd_addr` carries that address. `pm_rd_en` is 0 for writes and when no operation is requested.
- R3: `rd_valid` is 1 in exactly the cycle after a read request and 0 in every other cycle.
- R4: A low-lane word read returns program bits 15:0. Pointer bit 0 has no effect.
- R5: A high-lane word read returns {8'h00, program bits 23:16}.
- R6: In byte mode, pointer bit 0 = 0 picks bits 7:0 of the lane and pointer bit 0 = 1 picks bits 15:8. The byte is returned zero-extended, so a byte read at the high lane with bit 0 = 1 returns 0x0000.
- R7: A word address with bit 22 = 0 is implemented when it is below USER_WORDS (default 0x2000). One with bit 22 = 1 is implemented when its bits 21:0 are below CFG_WORDS (default 0x10). A read elsewhere keeps `pm_rd_en` at 0 and returns 0x0000 with `rd_valid`.
- R8: A low-lane write in word mode loads latch bits 15:0 from `op_wdata`. In byte mode it loads `op_wdata[7:0]` into latch bits 7:0 (pointer bit 0 = 0) or into bits 15:8 (pointer bit 0 = 1). Latch bits 23:16 are not changed.
- R9: A high-lane write in word mode, or in byte mode with pointer bit 0 = 0, loads `op_wdata[7:0]` into latch bits 23:16. A byte write with pointer bit 0 = 1 is discarded. Latch bits 15:0 are not changed.
- R10: Every write records its word address on `latch_addr` one clock later.
- R11: After reset, `rd_valid`, `rd_data`, `latch_q` and `latch_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| page_wr_en | input | 1 | Load the page register |
| page_wr_data | input | 16 | Page write value; only bits 7:0 are kept |
| page_rd_data | output | 16 | Page register, zero-extended |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | Lane and direction (R2 encoding) |
| op_byte | input | 1 | 1 = byte mode, 0 = word mode |
| op_ptr | input | 16 | Data-space pointer; bit 0 is the byte select |
| op_wdata | input | 16 | Write data |
| pm_rd_en | output | 1 | Program memory read enable |
| pm_rd_addr | output | 23 | Program memory word address |
| pm_rd_data | input | 24 | Program memory word, valid in the enable cycle |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 16 | Read result |
| latch_q | output | 24 | Holding latch contents |
| latch_addr | output | 23 | Word address of the last write |

## Verification
The memory read port is combinational with the request, so the bench checks the enable and the address 1 ns after it drives an operation on a falling edge. Read results, latch contents, the latch address and the page readback each pass through one register. The bench checks them after the following falling edge, which puts exactly one rising edge between the stimulus and the check. The pulse check for R3 is made at the start of the next operation. By then a second rising edge with no request has passed, so `rd_valid` must be low again.

// File: rtl/tau_pkg.sv
`timescale 1ns/1ps
package tau_pkg;

   typedef enum logic [1:0] {
      TBL_RD_LO = 2'b00,
      TBL_RD_HI = 2'b01,
      TBL_WR_LO = 2'b10,
      TBL_WR_HI = 2'b11
   } tbl_op_e;

   function automatic logic op_is_write(input tbl_op_e op);
      return op[1];
   endfunction

   function automatic logic op_is_high(input tbl_op_e op);
      return op[0];
   endfunction

endpackage

// File: rtl/tau_page_reg.sv
`timescale 1ns/1ps
module tau_page_reg #(
   parameter int unsigned PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PAGE_W-1:0] wr_data,
   output logic [PAGE_W-1:0] page_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         page_q <= '0;
      else if (wr_en)
         page_q <= wr_data;
   end

   // R1
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(page_q));

endmodule

// File: rtl/tau_addr_gen.sv
`timescale 1ns/1ps
module tau_addr_gen #(
   parameter int unsigned PAGE_W     = 8,
   parameter int unsigned PTR_W      = 16,
   parameter int unsigned USER_WORDS = 32'h2000,
   parameter int unsigned CFG_WORDS  = 32'h10
) (
   input  logic [PAGE_W-1:0]       page,
   input  logic [PTR_W-1:0]        ptr,
   output logic [PAGE_W+PTR_W-2:0] word_addr,
   output logic                    byte_sel,
   output logic                    implemented
);

   localparam int unsigned WA_W    = PAGE_W + PTR_W - 1;
   localparam int unsigned SPACE_W = WA_W - 1;
   localparam int unsigned SPACE_N = 32'd1 << SPACE_W;

   logic [SPACE_W-1:0] offset;
   logic               cfg_space;
   logic               user_ok;
   logic               cfg_ok;

   assign word_addr = {page, ptr[PTR_W-1:1]};
   assign byte_sel  = ptr[0];
   assign cfg_space = word_addr[WA_W-1];
   assign offset    = word_addr[SPACE_W-1:0];

   generate
      if (USER_WORDS >= SPACE_N) begin : g_user_full
         assign user_ok = 1'b1;
      end else begin : g_user_part
         assign user_ok = (32'(offset) < USER_WORDS);
      end
      if (CFG_WORDS >= SPACE_N) begin : g_cfg_full
         assign cfg_ok = 1'b1;
      end else begin : g_cfg_part
         assign cfg_ok = (32'(offset) < CFG_WORDS);
      end
   endgenerate

   assign implemented = cfg_space ? cfg_ok : user_ok;

endmodule

// File: rtl/tau_read_fmt.sv
`timescale 1ns/1ps
module tau_read_fmt #(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned LANE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              hi,
   input  logic              byte_mode,
   input  logic              byte_sel,
   input  logic              implemented,
   input  logic [WORD_W-1:0] pm_data,
   output logic              rd_valid,
   output logic [LANE_W-1:0] rd_data
);

   localparam int unsigned HI_W   = WORD_W - LANE_W;
   localparam int unsigned BYTE_W = 8;

   logic [LANE_W-1:0] lane;
   logic [LANE_W-1:0] picked;

   assign lane = hi ? LANE_W'(pm_data[WORD_W-1:LANE_W]) : pm_data[LANE_W-1:0];

   always_comb begin
      if (!implemented)
         picked = '0;
      else if (!byte_mode)
         picked = lane;
      else if (byte_sel)
         picked = LANE_W'(lane[LANE_W-1:BYTE_W]);
      else
         picked = LANE_W'(lane[BYTE_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= issue;
         if (issue)
            rd_data <= picked;
      end
   end

   // R3
   rdv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> rd_valid);
   // R3
   rdv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> !rd_valid);
   // R5
   phantom_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(hi)) |-> (rd_data[LANE_W-1:HI_W] == '0));
   // R7
   unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !$past(implemented)) |-> (rd_data == '0));

endmodule

// File: rtl/tau_write_latch.sv
`timescale 1ns/1ps
module tau_write_latch #(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned LANE_W = 16,
   parameter int unsigned WA_W   = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              hi,
   input  logic              byte_mode,
   input  logic              byte_sel,
   input  logic [LANE_W-1:0] wdata,
   input  logic [WA_W-1:0]   word_addr,
   output logic [WORD_W-1:0] latch_q,
   output logic [WA_W-1:0]   latch_addr
);

   localparam int unsigned HI_W   = WORD_W - LANE_W;
   localparam int unsigned BYTE_W = 8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q    <= '0;
         latch_addr <= '0;
      end else if (we) begin
         latch_addr <= word_addr;
         if (!hi) begin
            if (!byte_mode)
               latch_q[LANE_W-1:0] <= wdata;
            else if (byte_sel)
               latch_q[LANE_W-1:BYTE_W] <= wdata[BYTE_W-1:0];
            else
               latch_q[BYTE_W-1:0] <= wdata[BYTE_W-1:0];
         end else if (!byte_mode || !byte_sel) begin
            latch_q[WORD_W-1:LANE_W] <= wdata[HI_W-1:0];
         end
      end
   end

   // R9
   phantom_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && hi && byte_mode && byte_sel) |=> $stable(latch_q));
   // R8
   lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !hi) |=> $stable(latch_q[WORD_W-1:LANE_W]));
   // R9
   hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && hi) |=> $stable(latch_q[LANE_W-1:0]));
   // R10
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(latch_addr));

endmodule

// File: rtl/tbl_access_unit.sv
`timescale 1ns/1ps
module tbl_access_unit #(
   parameter int unsigned PAGE_W     = 8,
   parameter int unsigned PTR_W      = 16,
   parameter int unsigned WORD_W     = 24,
   parameter int unsigned USER_WORDS = 32'h2000,
   parameter int unsigned CFG_WORDS  = 32'h10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     page_wr_en,
   input  logic [15:0]              page_wr_data,
   output logic [15:0]              page_rd_data,
   input  logic                     op_valid,
   input  logic [1:0]               op_code,
   input  logic                     op_byte,
   input  logic [PTR_W-1:0]         op_ptr,
   input  logic [15:0]              op_wdata,
   output logic                     pm_rd_en,
   output logic [PAGE_W+PTR_W-2:0]  pm_rd_addr,
   input  logic [WORD_W-1:0]        pm_rd_data,
   output logic                     rd_valid,
   output logic [15:0]              rd_data,
   output logic [WORD_W-1:0]        latch_q,
   output logic [PAGE_W+PTR_W-2:0]  latch_addr
);
   import tau_pkg::*;

   localparam int unsigned LANE_W = 16;
   localparam int unsigned HI_W   = WORD_W - LANE_W;
   localparam int unsigned WA_W   = PAGE_W + PTR_W - 1;

   generate
      if (PTR_W != LANE_W) begin : g_bad_ptr
         $error("tbl_access_unit: PTR_W must equal the 16-bit data width");
      end
      if (HI_W < 1 || HI_W > 8) begin : g_bad_word
         $error("tbl_access_unit: WORD_W must leave 1 to 8 bits above the low lane");
      end
      if (PAGE_W < 2 || PAGE_W > LANE_W) begin : g_bad_page
         $error("tbl_access_unit: PAGE_W out of range");
      end
      if (USER_WORDS == 0 || CFG_WORDS == 0) begin : g_bad_size
         $error("tbl_access_unit: space sizes must be non-zero");
      end
   endgenerate

   tbl_op_e           op;
   logic              is_wr;
   logic              is_hi;
   logic              rd_issue;
   logic              wr_issue;
   logic [PAGE_W-1:0] page_q;
   logic [WA_W-1:0]   word_addr;
   logic              byte_sel;
   logic              implemented;
   logic              unused_page_hi;

   assign op       = tbl_op_e'(op_code);
   assign is_wr    = op_is_write(op);
   assign is_hi    = op_is_high(op);
   assign rd_issue = op_valid && !is_wr;
   assign wr_issue = op_valid && is_wr;

   assign unused_page_hi = ^page_wr_data[15:PAGE_W];

   tau_page_reg #(.PAGE_W(PAGE_W)) u_page (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (page_wr_en),
      .wr_data (page_wr_data[PAGE_W-1:0]),
      .page_q  (page_q)
   );

   assign page_rd_data = 16'(page_q);

   tau_addr_gen #(
      .PAGE_W     (PAGE_W),
      .PTR_W      (PTR_W),
      .USER_WORDS (USER_WORDS),
      .CFG_WORDS  (CFG_WORDS)
   ) u_addr (
      .page        (page_q),
      .ptr         (op_ptr),
      .word_addr   (word_addr),
      .byte_sel    (byte_sel),
      .implemented (implemented)
   );

   assign pm_rd_en   = rd_issue && implemented;
   assign pm_rd_addr = word_addr;

   tau_read_fmt #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue       (rd_issue),
      .hi          (is_hi),
      .byte_mode   (op_byte),
      .byte_sel    (byte_sel),
      .implemented (implemented),
      .pm_data     (pm_rd_data),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data)
   );

   tau_write_latch #(.WORD_W(WORD_W), .LANE_W(LANE_W), .WA_W(WA_W)) u_wl (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (wr_issue),
      .hi         (is_hi),
      .byte_mode  (op_byte),
      .byte_sel   (byte_sel),
      .wdata      (op_wdata),
      .word_addr  (word_addr),
      .latch_q    (latch_q),
      .latch_addr (latch_addr)
   );

   // R2
   pm_en_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pm_rd_en |-> (op_valid && !op_code[1]));
   // R1
   page_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      page_wr_en |=> (page_rd_data[15:PAGE_W] == '0));

endmodule

// File: tb/tbl_access_unit_bench.sv
`timescale 1ns/1ps
module tbl_access_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int unsigned USER_W = 32'h2000;
   localparam int unsigned CFG_W  = 32'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        page_wr_en = 1'b0;
   logic [15:0] page_wr_data = '0;
   logic [15:0] page_rd_data;
   logic        op_valid = 1'b0;
   logic [1:0]  op_code = '0;
   logic        op_byte = 1'b0;
   logic [15:0] op_ptr = '0;
   logic [15:0] op_wdata = '0;
   logic        pm_rd_en;
   logic [22:0] pm_rd_addr;
   logic [23:0] pm_rd_data;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic [23:0] latch_q;
   logic [22:0] latch_addr;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0]  m_page = '0;
   logic [23:0] m_latch = '0;
   logic [22:0] m_laddr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [23:0] mem_fn(input logic [22:0] a);
      logic [31:0] t;
      t = {9'h0, a} * 32'h0019_660D + 32'h3C6E_F35F;
      return t[27:4];
   endfunction

   assign pm_rd_data = mem_fn(pm_rd_addr);

   tbl_access_unit u_tbl_access_unit (
      .clk(clk), .rst_n(rst_n),
      .page_wr_en(page_wr_en), .page_wr_data(page_wr_data), .page_rd_data(page_rd_data),
      .op_valid(op_valid), .op_code(op_code), .op_byte(op_byte), .op_ptr(op_ptr),
      .op_wdata(op_wdata), .pm_rd_en(pm_rd_en), .pm_rd_addr(pm_rd_addr),
      .pm_rd_data(pm_rd_data), .rd_valid(rd_valid), .rd_data(rd_data),
      .latch_q(latch_q), .latch_addr(latch_addr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic exp_impl(input logic [22:0] wa);
      if (wa[22]) return 32'(wa[21:0]) < CFG_W;
      return 32'(wa[21:0]) < USER_W;
   endfunction

   function automatic logic [15:0] exp_read(input logic hi, input logic bm,
                                            input logic b0, input logic [23:0] d,
                                            input logic impl);
      logic [15:0] lane;
      if (!impl) return 16'h0;
      lane = hi ? {8'h00, d[23:16]} : d[15:0];
      if (!bm) return lane;
      return b0 ? {8'h00, lane[15:8]} : {8'h00, lane[7:0]};
   endfunction

   task automatic set_page(input logic [15:0] v);
      @(negedge clk);
      page_wr_en = 1'b1;
      page_wr_data = v;
      @(negedge clk);
      page_wr_en = 1'b0;
      m_page = v[7:0];
      #1;
      chk("R1 page readback", 32'(page_rd_data), {24'h0, v[7:0]});
   endtask

   task automatic run_op(input logic [1:0] code, input logic bm,
                         input logic [15:0] ptr, input logic [15:0] wd);
      logic [22:0] wa;
      logic        impl;
      logic [15:0] er;
      string       tag;
      @(negedge clk);
      #1;
      chk("R3 strobe low between ops", 32'(rd_valid), 32'd0);
      op_valid = 1'b1;
      op_code  = code;
      op_byte  = bm;
      op_ptr   = ptr;
      op_wdata = wd;
      #1;
      wa   = {m_page, ptr[15:1]};
      impl = exp_impl(wa);
      if (!code[1]) begin
         chk(impl ? "R2 read enable" : "R7 no enable on unimplemented",
             32'(pm_rd_en), 32'(impl));
         if (impl) chk("R2 word address", 32'(pm_rd_addr), 32'(wa));
      end else begin
         chk("R2 no enable on write", 32'(pm_rd_en), 32'd0);
      end
      er = exp_read(code[0], bm, ptr[0], mem_fn(wa), impl);
      @(negedge clk);
      op_valid = 1'b0;
      #1;
      if (!code[1]) begin
         if (!impl)     tag = "R7 unimplemented read";
         else if (bm)   tag = "R6 byte read";
         else if (code[0]) tag = "R5 high word read";
         else           tag = "R4 low word read";
         chk("R3 strobe after read", 32'(rd_valid), 32'd1);
         chk(tag, 32'(rd_data), 32'(er));
      end else begin
         if (!code[0]) begin
            if (!bm) m_latch[15:0] = wd;
            else if (ptr[0]) m_latch[15:8] = wd[7:0];
            else m_latch[7:0] = wd[7:0];
            tag = "R8 low write";
         end else begin
            if (!bm || !ptr[0]) m_latch[23:16] = wd[7:0];
            tag = "R9 high write";
         end
         m_laddr = wa;
         chk("R3 no strobe after write", 32'(rd_valid), 32'd0);
         chk(tag, 32'(latch_q), 32'(m_latch));
         chk("R10 latch address", 32'(latch_addr), 32'(m_laddr));
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      chk("R11 rd_valid reset", 32'(rd_valid), 32'd0);
      chk("R11 rd_data reset", 32'(rd_data), 32'd0);
      chk("R11 latch reset", 32'(latch_q), 32'd0);
      chk("R11 latch addr reset", 32'(latch_addr), 32'd0);
      chk("R1 page reset", 32'(page_rd_data), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // Directed corner cases
      run_op(2'b00, 1'b0, 16'h0124, 16'h0);  // R4 even pointer
      run_op(2'b00, 1'b0, 16'h0125, 16'h0);  // R4 odd pointer, same word
      run_op(2'b01, 1'b0, 16'h0124, 16'h0);  // R5
      run_op(2'b00, 1'b1, 16'h0200, 16'h0);  // R6 low byte
      run_op(2'b00, 1'b1, 16'h0201, 16'h0);  // R6 high byte
      run_op(2'b01, 1'b1, 16'h0200, 16'h0);  // R6 high lane byte 0
      run_op(2'b01, 1'b1, 16'h0201, 16'h0);  // R6 phantom byte
      run_op(2'b00, 1'b0, 16'h3FFE, 16'h0);  // R7 last user word
      run_op(2'b00, 1'b0, 16'h4000, 16'h0);  // R7 first hole
      run_op(2'b10, 1'b0, 16'h0010, 16'hBEEF); // R8
      run_op(2'b10, 1'b1, 16'h0011, 16'h1234); // R8 byte hi
      run_op(2'b10, 1'b1, 16'h0010, 16'h5678); // R8 byte lo
      run_op(2'b11, 1'b0, 16'h0012, 16'hAA55); // R9
      run_op(2'b11, 1'b1, 16'h0013, 16'h00FF); // R9 phantom discarded
      run_op(2'b11, 1'b1, 16'h0012, 16'h0033); // R9 byte 0
      set_page(16'hAB80);                      // R1 upper bits dropped
      run_op(2'b01, 1'b0, 16'h001E, 16'h0);  // R7 last config word
      run_op(2'b00, 1'b0, 16'h0020, 16'h0);  // R7 config hole
      run_op(2'b11, 1'b0, 16'h0004, 16'h00C3); // R10 config address
      set_page(16'h0001);
      run_op(2'b00, 1'b0, 16'h0000, 16'h0);  // R7 page 1 unimplemented

      // Constrained random
      for (int i = 0; i < 400; i++) begin
         r = $urandom;
         if (r[3:0] == 4'h0) begin
            case (r[5:4])
               2'd0, 2'd1: set_page(16'h0000);
               2'd2:       set_page(16'h0080);
               default:    set_page(16'($urandom));
            endcase
         end else begin
            logic [15:0] p;
            p = 16'($urandom);
            if (r[8]) p = (m_page == 8'h80) ? (p & 16'h003F) : (p & 16'h3FFF);
            run_op(r[10:9], r[11], p, 16'($urandom));
         end
      end

      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule